// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block connects a CPU register port to an on-chip nonvolatile byte array. Software sees three registers: an address register, a data register and a control register with three bits (read strobe, write-in-progress, write arm). A read returns the stored byte into the data register at once and holds the CPU for a few cycles. A write is guarded by an unlock sequence. Software first sets the arm bit, which clears itself after a short window. It then sets the write bit while the arm is still live. The write bit stays high for the whole programming time, which is counted on a separate calibrated oscillator, and hardware clears it at the end.

While a write is in progress the address and data registers are frozen and read requests do nothing. The latched byte is committed to the array when the oscillator-domain counter finishes. Start and completion events cross between the CPU clock and the oscillator clock as toggles through multi-flop synchronizers. The array itself lives outside the block: the block presents an address, write data and a one-cycle write strobe, and takes combinational read data back.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset all three registers read as zero, `cpu_stall` is low and `mem_we` is low.
- R2: When no write is in progress, a register write with `bus_sel`=0 loads the address and `bus_sel`=1 loads the data byte. Both read back through `bus_rdata` under the same select, and `mem_addr` always shows the address register.
- R3: Writing the control register (`bus_sel`=2) with bit 2 set arms the unlock. Bit 2 reads 1 for exactly MWE_CYCLES cycles and then returns to 0 by itself.
- R4: A control write with bit 1 set starts a write only if the arm was live before that access. A write attempt without an arm, after the arm has expired, or in the same access that sets the arm starts nothing.
- R5: A write start raises `cpu_stall` for exactly WR_STALL (2) cycles.
- R6: A control write with bit 0 set, when no write is in progress, loads the data register from the array at the current address on the next clock edge. It raises `cpu_stall` for RD_STALL (4) cycles, and control bit 0 reads 1 during that stall.
- R7: While a write is in progress, writes to the address and data registers are ignored and a read request has no effect.
- R8: Control bit 1 stays 1 from the start for the programming time of PROG_CYCLES oscillator cycles, plus synchronizer latency, and then clears without software action.
- R9: At the end of programming `mem_we` is high for exactly one cycle with the latched address and data. Control bit 1 reads 0 from the following cycle on.
- R10: Writing zeros to the control register never clears the arm or an ongoing write, and a second write request during a write does not restart it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset, CPU domain |
| osc_clk | input | 1 | Calibrated oscillator clock that times programming |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Readback of the selected register |
| cpu_stall | output | 1 | Holds the CPU after a read or a write start |
| mem_addr | output | ADDR_W | Array address (the address register) |
| mem_wdata | output | DATA_W | Byte committed to the array |
| mem_we | output | 1 | One-cycle array write strobe at programming end |
| mem_rdata | input | DATA_W | Combinational array read data |

## Verification
The bound checker watches several rules on every cycle. The address and data registers must not move while the write bit is high. A write may only begin out of a live arm, and it must raise the stall. The array strobe may only appear inside a write and must clear it. The arm may never outlive its window, counted by a checker counter. A read request must stall and load the array byte. Only the bench scenarios can show the things that need a history across many cycles: that a late or same-access write request starts nothing, that the programming time falls within its window after crossing both clock domains, and that bytes committed to the array come back through later reads.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int ADDR_W_DEF = 10;
    localparam int DATA_W_DEF = 8;

    // control register bit positions (software-visible)
    localparam int BIT_RD  = 0;
    localparam int BIT_WR  = 1;
    localparam int BIT_ARM = 2;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } nvm_sel_e;

    typedef struct packed {
        logic arm;
        logic wr;
        logic rd;
    } nvm_ctrl_t;

    typedef struct packed {
        logic addr_wr;
        logic data_wr;
        logic arm_req;
        logic wr_req;
        logic rd_req;
    } nvm_req_t;

    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic nvm_req_t decode_req(logic we, nvm_sel_e sel, logic [2:0] bits);
        nvm_req_t r;
        r.addr_wr = we && (sel == SEL_ADDR);
        r.data_wr = we && (sel == SEL_DATA);
        r.arm_req = we && (sel == SEL_CTRL) && bits[BIT_ARM];
        r.wr_req  = we && (sel == SEL_CTRL) && bits[BIT_WR];
        r.rd_req  = we && (sel == SEL_CTRL) && bits[BIT_RD];
        return r;
    endfunction

endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nvm_down_timer.sv
module nvm_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         active
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int PROG_CYCLES = 26368,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic osc_rst,
    input  logic start_tgl,
    output logic done_tgl
);
    import nvm_pkg::*;

    localparam int PW = cnt_w(PROG_CYCLES);

    logic start_s, start_prev_q, start_evt;
    logic run, run_prev_q, done_q;

    nvm_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk (osc_clk),
        .rst (osc_rst),
        .d   (start_tgl),
        .q   (start_s)
    );

    assign start_evt = start_s ^ start_prev_q;

    nvm_down_timer #(.W(PW)) u_prog_cnt (
        .clk      (osc_clk),
        .rst      (osc_rst),
        .load     (start_evt),
        .load_val (PW'(PROG_CYCLES)),
        .active   (run)
    );

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            start_prev_q <= 1'b0;
            run_prev_q   <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            start_prev_q <= start_s;
            run_prev_q   <= run;
            if (run_prev_q && !run) done_q <= ~done_q;
        end
    end

    assign done_tgl = done_q;
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int MWE_CYCLES  = 4,
    parameter int WR_STALL    = 2,
    parameter int RD_STALL    = 4,
    parameter int PROG_CYCLES = 26368,
    parameter int SYNC_STAGES = 2,
    localparam int BUS_W      = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_clk,
    input  logic              osc_rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              cpu_stall,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int ARM_W   = cnt_w(MWE_CYCLES);
    localparam int STALL_W = cnt_w(max2(WR_STALL, RD_STALL));

    nvm_sel_e          sel_e;
    nvm_req_t          req;
    nvm_ctrl_t         ctrl_view;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              we_q;
    logic              armed;
    logic              start_wr, do_rd;
    logic              stall_rd_q, stall_on;
    logic              start_tgl_q, done_tgl, done_s, done_prev_q, done_evt;

    assign sel_e = nvm_sel_e'(bus_sel);
    assign req   = decode_req(bus_we, sel_e, bus_wdata[2:0]);

    // unlock window
    nvm_down_timer #(.W(ARM_W)) u_arm (
        .clk      (clk),
        .rst      (rst),
        .load     (req.arm_req),
        .load_val (ARM_W'(MWE_CYCLES)),
        .active   (armed)
    );

    assign start_wr = req.wr_req && armed && !we_q;
    assign do_rd    = req.rd_req && !we_q && !start_wr;

    // CPU hold
    nvm_down_timer #(.W(STALL_W)) u_stall (
        .clk      (clk),
        .rst      (rst),
        .load     (start_wr || do_rd),
        .load_val (start_wr ? STALL_W'(WR_STALL) : STALL_W'(RD_STALL)),
        .active   (stall_on)
    );

    // completion path back from the oscillator domain
    nvm_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_prog (
        .osc_clk   (osc_clk),
        .osc_rst   (osc_rst),
        .start_tgl (start_tgl_q),
        .done_tgl  (done_tgl)
    );

    nvm_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk (clk),
        .rst (rst),
        .d   (done_tgl),
        .q   (done_s)
    );

    assign done_evt = done_s ^ done_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q      <= '0;
            data_q      <= '0;
            we_q        <= 1'b0;
            stall_rd_q  <= 1'b0;
            start_tgl_q <= 1'b0;
            done_prev_q <= 1'b0;
        end else begin
            done_prev_q <= done_s;
            if (req.addr_wr && !we_q) addr_q <= bus_wdata[ADDR_W-1:0];
            if (do_rd)
                data_q <= mem_rdata;
            else if (req.data_wr && !we_q)
                data_q <= bus_wdata[DATA_W-1:0];
            if (start_wr) begin
                we_q        <= 1'b1;
                start_tgl_q <= ~start_tgl_q;
            end else if (done_evt) begin
                we_q        <= 1'b0;
            end
            if (start_wr || do_rd) stall_rd_q <= do_rd;
        end
    end

    assign ctrl_view.arm = armed;
    assign ctrl_view.wr  = we_q;
    assign ctrl_view.rd  = stall_on && stall_rd_q;

    always_comb begin
        unique case (sel_e)
            SEL_ADDR: bus_rdata = BUS_W'(addr_q);
            SEL_DATA: bus_rdata = BUS_W'(data_q);
            SEL_CTRL: bus_rdata = BUS_W'(ctrl_view);
            default:  bus_rdata = '0;
        endcase
    end

    assign cpu_stall = stall_on;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
    assign mem_we    = done_evt && we_q;
endmodule

// File: rtl/nvm_access_ctrl_chk.sv
module nvm_access_ctrl_chk #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int MWE_CYCLES = 4,
    localparam int BUS_W     = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [1:0]        bus_sel,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              cpu_stall,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_we,
    input logic [DATA_W-1:0] data_q,
    input logic              we_q,
    input logic              armed
);
    localparam int HW = $clog2(MWE_CYCLES + 2);

    logic ctrl_wr;
    logic [HW-1:0] hold_cnt;

    assign ctrl_wr = bus_we && (bus_sel == 2'd2);

    always_ff @(posedge clk) begin
        if (rst)
            hold_cnt <= HW'(MWE_CYCLES + 1);
        else if (ctrl_wr && bus_wdata[2])
            hold_cnt <= '0;
        else if (hold_cnt != HW'(MWE_CYCLES + 1))
            hold_cnt <= hold_cnt + 1'b1;
    end

    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !(armed && (hold_cnt >= HW'(MWE_CYCLES)))); // R3
    AST_START_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(we_q) |-> $past(armed)); // R4
    AST_WRITE_HOLDS_CPU: assert property (@(posedge clk) disable iff (rst)
        $rose(we_q) |-> cpu_stall); // R5
    AST_READ_HOLDS_CPU: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[0] && !we_q && !(bus_wdata[1] && armed))
        |=> cpu_stall && (data_q == $past(mem_rdata))); // R6
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        we_q |=> $stable(mem_addr)); // R7
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
        we_q |=> $stable(data_q)); // R7
    AST_STROBE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> we_q); // R9
    AST_STROBE_ENDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (!we_q && !mem_we)); // R8
endmodule

bind nvm_access_ctrl nvm_access_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MWE_CYCLES (MWE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .cpu_stall (cpu_stall),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .data_q    (data_q),
    .we_q      (we_q),
    .armed     (armed)
);

// File: tb/nvm_access_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_access_ctrl_tb;
    localparam int AW = 10, DW = 8, BW = 10;
    localparam int MWE = 4, WRS = 2, RDS = 4, PROG = 40;
    localparam int CPU_NS = 4, OSC_NS = 14;
    localparam int MIN_LAT = PROG * OSC_NS / CPU_NS;
    localparam int MAX_LAT = MIN_LAT + 30;

    logic clk = 1'b0, osc_clk = 1'b0;
    logic rst = 1'b1, osc_rst = 1'b1;
    logic bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd2;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic cpu_stall, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #(CPU_NS/2) clk = ~clk;
    always #(OSC_NS/2) osc_clk = ~osc_clk;

    nvm_access_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .MWE_CYCLES(MWE), .WR_STALL(WRS),
        .RD_STALL(RDS), .PROG_CYCLES(PROG), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // behavioural byte array
    logic [DW-1:0] mem [0:(1<<AW)-1];
    initial for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    int errors = 0, checks = 0;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // reference model
    int m_addr, m_data, m_mwe, m_stall, start_cyc, cyc;
    bit m_rd, m_busy, pend_done, late_flag;
    int m_mem [0:(1<<AW)-1];
    bit busy_o, arm_o;
    int addr_o;

    function automatic int exp_rdata(int s);
        case (s)
            0: return m_addr;
            1: return m_data;
            2: return ((m_mwe > 0) ? 4 : 0) + (m_busy ? 2 : 0) + ((m_stall > 0 && m_rd) ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_data = 0; m_mwe = 0; m_stall = 0; m_rd = 0;
            m_busy = 0; pend_done = 0; cyc = 0; late_flag = 0;
            for (int i = 0; i < (1<<AW); i++) m_mem[i] = 0;
        end else begin
            busy_o = m_busy; arm_o = (m_mwe > 0); addr_o = m_addr;
            if (pend_done) begin
                m_mem[m_addr] = m_data; m_busy = 0; pend_done = 0;
            end
            if (m_mwe > 0) m_mwe--;
            if (m_stall > 0) m_stall--;
            if (bus_we) begin
                case (bus_sel)
                    2'd0: if (!busy_o) m_addr = int'(bus_wdata);
                    2'd1: if (!busy_o) m_data = int'(bus_wdata[DW-1:0]);
                    2'd2: begin
                        if (bus_wdata[2]) m_mwe = MWE;
                        if (bus_wdata[1] && arm_o && !busy_o) begin
                            m_busy = 1; m_stall = WRS; m_rd = 0; start_cyc = cyc;
                        end else if (bus_wdata[0] && !busy_o) begin
                            m_data = m_mem[addr_o]; m_stall = RDS; m_rd = 1;
                        end
                    end
                    default: ;
                endcase
            end
            cyc++;
            #1;
            check("R5/R6 cpu_stall", cpu_stall, m_stall > 0);
            check("R2/R7 mem_addr", mem_addr, m_addr);
            check("R2/R3/R4 bus_rdata", bus_rdata, exp_rdata(int'(bus_sel)));
            if (mem_we) begin
                check("R9 strobe inside write", 1, m_busy);
                check("R9 mem_addr", mem_addr, m_addr);
                check("R9 mem_wdata", mem_wdata, m_data);
                checks++;
                if (cyc - start_cyc < MIN_LAT || cyc - start_cyc > MAX_LAT) begin
                    errors++;
                    $display("FAIL R8 duration: actual %0d expected %0d..%0d",
                             cyc - start_cyc, MIN_LAT, MAX_LAT);
                end
                pend_done = 1;
            end
            if (m_busy && !late_flag && (cyc - start_cyc > MAX_LAT)) begin
                late_flag = 1; checks++; errors++;
                $display("FAIL R8 write never ended: actual %0d expected <= %0d",
                         cyc - start_cyc, MAX_LAT);
            end
        end
    end

    task automatic wr(int s, int v);
        bus_we = 1'b1; bus_sel = 2'(s); bus_wdata = BW'(v);
        @(negedge clk);
        bus_we = 1'b0; bus_sel = 2'd2;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(string tag, int s, int exp);
        bus_sel = 2'(s);
        #0.5;
        check(tag, bus_rdata, exp);
        bus_sel = 2'd2;
    endtask

    task automatic wait_write_done();
        for (int i = 0; i < 400; i++) begin
            if (bus_rdata[1] == 1'b0) break;
            idle(1);
        end
        check("R8 write bit cleared", bus_rdata[1], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        osc_rst = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        peek("R1 addr", 0, 0);
        peek("R1 data", 1, 0);
        peek("R1 ctrl", 2, 0);
        check("R1 stall", cpu_stall, 0);
        check("R1 mem_we", mem_we, 0);

        // R2 register loads
        wr(0, 5); wr(1, 'hA5);
        peek("R2 addr", 0, 5);
        peek("R2 data", 1, 'hA5);

        // R4 write without arm
        wr(2, 'b010);
        peek("R4 no arm, no start", 2, 0);
        idle(2);

        // R3 arm window boundary
        wr(2, 'b100);
        peek("R3 armed", 2, 4);
        idle(3);
        peek("R3 still armed last cycle", 2, 4);
        idle(1);
        peek("R3 expired", 2, 0);
        // R4 late request (fifth edge after arming)
        wr(2, 'b010);
        peek("R4 late request ignored", 2, 0);
        check("R4 no stall", cpu_stall, 0);

        // R4 arm and write in one access
        wr(2, 'b110);
        peek("R4 same-access start refused", 2, 4);
        idle(5);

        // R4/R5 proper start
        wr(2, 'b100); wr(2, 'b010);
        peek("R4 started", 2, 6);
        check("R5 stall first", cpu_stall, 1);
        idle(1);
        check("R5 stall second", cpu_stall, 1);
        idle(1);
        check("R5 stall over", cpu_stall, 0);

        // R7 locks while busy, R10 no clear/restart
        wr(0, 7); wr(1, 'h11); wr(2, 'b001);
        peek("R7 addr locked", 0, 5);
        peek("R7 data locked", 1, 'hA5);
        peek("R7 read ignored", 2, 2);
        check("R7 no read stall", cpu_stall, 0);
        wr(2, 'b000);
        peek("R10 zero write keeps busy", 2, 2);
        wr(2, 'b110); wr(2, 'b010);
        idle(6);
        wait_write_done();

        // R6 read back committed byte
        wr(1, 0); wr(0, 5); wr(2, 'b001);
        peek("R6 data loaded", 1, 'hA5);
        peek("R6 read bit during stall", 2, 1);
        check("R6 stall", cpu_stall, 1);
        idle(3);
        check("R6 stall last cycle", cpu_stall, 1);
        idle(1);
        check("R6 stall over", cpu_stall, 0);
        peek("R6 read bit cleared", 2, 0);

        // R4 boundary: request on fourth edge after arming
        wr(0, 1023); wr(1, 'h3C); wr(2, 'b100);
        idle(3);
        wr(2, 'b010);
        peek("R4 fourth-edge start", 2, 2);
        wait_write_done();
        idle(3);
        wr(1, 0); wr(2, 'b001);
        peek("R9 committed byte at top address", 1, 'h3C);
        idle(5);

        // R6 unwritten location
        wr(0, 300); wr(2, 'b001);
        peek("R6 blank location", 1, 0);
        idle(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule